// File: doc/BRIEF.md
# Layered Fold Coincidence Trigger

This block derives a single event trigger from a stack of detector layers read out on two orthogonal planes. For every layer and plane, an upstream stage reports four fold flags. Fold m means that m neighbouring strips in that layer fired. For each plane, the block looks for a run of adjacent layers that all carry the same fold flag. The run length it needs drops by one for each step up in fold: 5 layers at fold 1, 4 at fold 2, 3 at fold 3 and 2 at fold 4.

All flags and the layer enable mask are registered on the same clock edge, so every layer is judged on the same cycle. Any matching fold on either plane raises the combined condition. The rising edge of the combined condition produces a one-cycle trigger pulse, subject to a programmable dead time. Saturating counters record the triggers and each plane's coincidence onsets. A synchronous input clears all the counters.

Top module: `layer_fold_trigger`

## Requirements
- R1: While reset is asserted and right after it, `trigPulse` is low and `trigCount`, `xHitCount` and `yHitCount` are zero.
- R2: Fold flag m (1..4) of layer L (0..NUM_LAYERS-1) is bit L*4+(m-1) of `xFold`/`yFold`. Flags present before clock edge k give `trigPulse` high in the cycle after edge k+1, and low in the cycle after edge k.
- R3: A plane matches when fold 1 is set in 5 adjacent layers, fold 2 in 4, fold 3 in 3, or fold 4 in 2. A run one layer shorter does not match, and runs made of different folds do not combine.
- R4: A layer whose `layerEnable` bit is low counts as having no flags, so it breaks any run through it.
- R5: The combined condition is the OR of both planes. `trigPulse` is high for exactly one cycle on each rising edge of that condition, and a held condition gives one pulse.
- R6: After a pulse, rising edges at the next `deadTime` clock edges give no pulse, and they are not held over until later.
- R7: `trigCount` rises by one on the edge that raises `trigPulse`, and changes at no other time.
- R8: `xHitCount` (`yHitCount`) rises by one on each rising edge of that plane's own condition. This happens during dead time too, and whether or not the other plane is already active.
- R9: Each counter stops at its all-ones value and does not wrap.
- R10: When `clrCnt` is high at a clock edge, all three counters read zero after that edge. This wins over an increment at the same edge and does not suppress the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clrCnt | input | 1 | Synchronous clear of the three counters |
| layerEnable | input | NUM_LAYERS | Per-layer enable; a low bit forces that layer's flags to zero |
| xFold | input | NUM_LAYERS*4 | X-plane fold flags, bit L*4+(m-1) |
| yFold | input | NUM_LAYERS*4 | Y-plane fold flags, same layout |
| deadTime | input | DEAD_W | Number of clock edges after a pulse during which retriggering is blocked |
| trigPulse | output | 1 | One-cycle final trigger |
| trigCount | output | CNT_W | Saturating count of triggers |
| xHitCount | output | CNT_W | Saturating count of X-plane coincidence onsets |
| yHitCount | output | CNT_W | Saturating count of Y-plane coincidence onsets |

## Verification
The bench uses the default 14 layers and the default 8-bit dead time, but builds the counters with CNT_W of 4. This lets about twenty triggers reach saturation, where the full width would need billions. With 14 layers, fold-4 pairs can sit at the top edge of the stack, and fold-1 runs can be placed around a masked layer in the middle.

// File: rtl/trig_pkg.sv
package trig_pkg;

  // Per-cycle coincidence state derived by the datapath
  typedef struct packed {
    logic anyCond;
    logic xCond;
    logic yCond;
  } planeStat_t;

  // Strobes issued by the control to the datapath
  typedef struct packed {
    logic fire;
    logic xRise;
    logic yRise;
    logic clear;
  } ctrlStrobe_t;

endpackage

// File: rtl/trig_run_detect.sv
// Consecutive-layer run search over one plane; the fold index f needs MAX_RUN-f layers
module trig_run_detect #(
  parameter int NUM_LAYERS = 14,
  parameter int NUM_FOLDS  = 4,
  parameter int MAX_RUN    = 5
) (
  input  logic [NUM_LAYERS*NUM_FOLDS-1:0] flags,
  output logic                            hit
);

  logic [NUM_FOLDS-1:0] foldHit;

  for (genvar f = 0; f < NUM_FOLDS; f++) begin : g_fold
    localparam int W = MAX_RUN - f;
    logic [NUM_LAYERS-1:0] column;

    for (genvar l = 0; l < NUM_LAYERS; l++) begin : g_col
      assign column[l] = flags[l*NUM_FOLDS + f];
    end

    if (W < 1 || W > NUM_LAYERS) begin : g_none
      assign foldHit[f] = 1'b0;
    end else begin : g_win
      localparam int NSTART = NUM_LAYERS - W + 1;
      logic [NSTART-1:0] window;
      for (genvar s = 0; s < NSTART; s++) begin : g_start
        assign window[s] = &column[s +: W];
      end
      assign foldHit[f] = |window;
    end
  end

  assign hit = |foldHit;

endmodule

// File: rtl/trig_sat_counter.sv
module trig_sat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clear) begin
      count <= '0;
    end else if (inc && (count != '1)) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/trig_datapath.sv
module trig_datapath
  import trig_pkg::*;
#(
  parameter int NUM_LAYERS = 14,
  parameter int NUM_FOLDS  = 4,
  parameter int MAX_RUN    = 5,
  parameter int CNT_W      = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_LAYERS-1:0]           layerEnable,
  input  logic [NUM_LAYERS*NUM_FOLDS-1:0] xFold,
  input  logic [NUM_LAYERS*NUM_FOLDS-1:0] yFold,
  input  ctrlStrobe_t                     strobe,
  output planeStat_t                      stat,
  output logic [CNT_W-1:0]                trigCount,
  output logic [CNT_W-1:0]                xHitCount,
  output logic [CNT_W-1:0]                yHitCount
);

  localparam int FLAG_W = NUM_LAYERS * NUM_FOLDS;

  logic [FLAG_W-1:0]     xQ, yQ;
  logic [NUM_LAYERS-1:0] enQ;
  logic [FLAG_W-1:0]     laneMask;
  logic                  xHit, yHit;

  // Align every layer on one edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xQ  <= '0;
      yQ  <= '0;
      enQ <= '0;
    end else begin
      xQ  <= xFold;
      yQ  <= yFold;
      enQ <= layerEnable;
    end
  end

  for (genvar l = 0; l < NUM_LAYERS; l++) begin : g_mask
    assign laneMask[l*NUM_FOLDS +: NUM_FOLDS] = {NUM_FOLDS{enQ[l]}};
  end

  trig_run_detect #(
    .NUM_LAYERS(NUM_LAYERS), .NUM_FOLDS(NUM_FOLDS), .MAX_RUN(MAX_RUN)
  ) xRun_i (
    .flags(xQ & laneMask),
    .hit  (xHit)
  );

  trig_run_detect #(
    .NUM_LAYERS(NUM_LAYERS), .NUM_FOLDS(NUM_FOLDS), .MAX_RUN(MAX_RUN)
  ) yRun_i (
    .flags(yQ & laneMask),
    .hit  (yHit)
  );

  assign stat.xCond   = xHit;
  assign stat.yCond   = yHit;
  assign stat.anyCond = xHit | yHit;

  trig_sat_counter #(.CNT_W(CNT_W)) trigCnt_i (
    .clk(clk), .rst_n(rst_n), .clear(strobe.clear), .inc(strobe.fire), .count(trigCount)
  );

  trig_sat_counter #(.CNT_W(CNT_W)) xCnt_i (
    .clk(clk), .rst_n(rst_n), .clear(strobe.clear), .inc(strobe.xRise), .count(xHitCount)
  );

  trig_sat_counter #(.CNT_W(CNT_W)) yCnt_i (
    .clk(clk), .rst_n(rst_n), .clear(strobe.clear), .inc(strobe.yRise), .count(yHitCount)
  );

endmodule

// File: rtl/trig_control.sv
module trig_control
  import trig_pkg::*;
#(
  parameter int DEAD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clrCnt,
  input  logic [DEAD_W-1:0] deadTime,
  input  planeStat_t        stat,
  output ctrlStrobe_t       strobe,
  output logic              trigPulse
);

  logic              anyPrev, xPrev, yPrev;
  logic [DEAD_W-1:0] deadCnt;
  logic              deadIdle;

  assign deadIdle     = (deadCnt == '0);
  assign strobe.fire  = stat.anyCond & ~anyPrev & deadIdle;
  assign strobe.xRise = stat.xCond & ~xPrev;
  assign strobe.yRise = stat.yCond & ~yPrev;
  assign strobe.clear = clrCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      anyPrev   <= 1'b0;
      xPrev     <= 1'b0;
      yPrev     <= 1'b0;
      deadCnt   <= '0;
      trigPulse <= 1'b0;
    end else begin
      anyPrev   <= stat.anyCond;
      xPrev     <= stat.xCond;
      yPrev     <= stat.yCond;
      trigPulse <= strobe.fire;
      if (strobe.fire) begin
        deadCnt <= deadTime;
      end else if (!deadIdle) begin
        deadCnt <= deadCnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/layer_fold_trigger.sv
module layer_fold_trigger
  import trig_pkg::*;
#(
  parameter int NUM_LAYERS = 14,
  parameter int NUM_FOLDS  = 4,
  parameter int MAX_RUN    = 5,
  parameter int DEAD_W     = 8,
  parameter int CNT_W      = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            clrCnt,
  input  logic [NUM_LAYERS-1:0]           layerEnable,
  input  logic [NUM_LAYERS*NUM_FOLDS-1:0] xFold,
  input  logic [NUM_LAYERS*NUM_FOLDS-1:0] yFold,
  input  logic [DEAD_W-1:0]               deadTime,
  output logic                            trigPulse,
  output logic [CNT_W-1:0]                trigCount,
  output logic [CNT_W-1:0]                xHitCount,
  output logic [CNT_W-1:0]                yHitCount
);

  planeStat_t  stat;
  ctrlStrobe_t strobe;

  trig_datapath #(
    .NUM_LAYERS(NUM_LAYERS), .NUM_FOLDS(NUM_FOLDS), .MAX_RUN(MAX_RUN), .CNT_W(CNT_W)
  ) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .layerEnable(layerEnable),
    .xFold      (xFold),
    .yFold      (yFold),
    .strobe     (strobe),
    .stat       (stat),
    .trigCount  (trigCount),
    .xHitCount  (xHitCount),
    .yHitCount  (yHitCount)
  );

  trig_control #(.DEAD_W(DEAD_W)) ctl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clrCnt   (clrCnt),
    .deadTime (deadTime),
    .stat     (stat),
    .strobe   (strobe),
    .trigPulse(trigPulse)
  );

endmodule

// File: rtl/trig_checker.sv
module trig_checker #(
  parameter int DEAD_W = 8,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clrCnt,
  input logic [DEAD_W-1:0] deadTime,
  input logic              trigPulse,
  input logic [CNT_W-1:0]  trigCount,
  input logic [CNT_W-1:0]  xHitCount,
  input logic [CNT_W-1:0]  yHitCount
);

  logic [31:0]       gap;
  logic [DEAD_W-1:0] dPrev;
  logic [DEAD_W-1:0] capDead;

  // Cycles since the last observed pulse, and the dead time in force when it fired
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap     <= '1;
      dPrev   <= '0;
      capDead <= '0;
    end else begin
      dPrev <= deadTime;
      if (trigPulse) begin
        gap     <= '0;
        capDead <= dPrev;
      end else if (gap != '1) begin
        gap <= gap + 1'b1;
      end
    end
  end

  a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    trigPulse |=> !trigPulse);

  a_r6_dead_window: assert property (@(posedge clk) disable iff (!rst_n)
    trigPulse |-> (gap >= {{(32-DEAD_W){1'b0}}, capDead}));

  a_r7_count_tracks_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (!clrCnt && trigCount != '1) |=>
      (trigCount == $past(trigCount) + {{(CNT_W-1){1'b0}}, trigPulse}));

  a_r8_hit_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (!clrCnt && xHitCount != '1 && yHitCount != '1) |=>
      ((xHitCount == $past(xHitCount) || xHitCount == $past(xHitCount) + 1) &&
       (yHitCount == $past(yHitCount) || yHitCount == $past(yHitCount) + 1)));

  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (trigCount == '1 && !clrCnt) |=> (trigCount == '1));

  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clrCnt |=> (trigCount == '0 && xHitCount == '0 && yHitCount == '0));

endmodule

bind layer_fold_trigger trig_checker #(.DEAD_W(DEAD_W), .CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .clrCnt   (clrCnt),
  .deadTime (deadTime),
  .trigPulse(trigPulse),
  .trigCount(trigCount),
  .xHitCount(xHitCount),
  .yHitCount(yHitCount)
);

// File: tb/layer_fold_trigger_tb_top.sv
module layer_fold_trigger_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NL   = 14;
  localparam int NF   = 4;
  localparam int DW   = 8;
  localparam int CW   = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clrCnt = 1'b0;
  logic [NL-1:0] layerEnable = '1;
  logic [NL*NF-1:0] xFold = '0;
  logic [NL*NF-1:0] yFold = '0;
  logic [DW-1:0] deadTime = '0;
  logic          trigPulse;
  logic [CW-1:0] trigCount, xHitCount, yHitCount;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  layer_fold_trigger #(.NUM_LAYERS(NL), .NUM_FOLDS(NF), .MAX_RUN(5), .DEAD_W(DW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .clrCnt(clrCnt), .layerEnable(layerEnable),
    .xFold(xFold), .yFold(yFold), .deadTime(deadTime), .trigPulse(trigPulse),
    .trigCount(trigCount), .xHitCount(xHitCount), .yHitCount(yHitCount)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  // ---------------- behavioural reference ----------------
  function automatic bit planeMatch(input logic [NL*NF-1:0] f, input logic [NL-1:0] en);
    bit found = 0;
    for (int m = 1; m <= NF; m++) begin
      int run = 0;
      int need = 6 - m;
      for (int l = 0; l < NL; l++) begin
        if (en[l] && f[l*NF + m - 1]) run++;
        else run = 0;
        if (run >= need) found = 1;
      end
    end
    return found;
  endfunction

  logic [NL*NF-1:0] sX, sY;
  logic [NL-1:0]    sEn;
  bit mPrevA, mPrevX, mPrevY, mPulse;
  int mDead, mTrig, mX, mY;

  always @(posedge clk) begin
    if (!rst_n) begin
      sX = '0; sY = '0; sEn = '0;
      mPrevA = 0; mPrevX = 0; mPrevY = 0; mPulse = 0;
      mDead = 0; mTrig = 0; mX = 0; mY = 0;
    end else begin
      bit xc, yc, ac, fire;
      xc = planeMatch(sX, sEn);
      yc = planeMatch(sY, sEn);
      ac = xc | yc;
      fire = ac && !mPrevA && (mDead == 0);
      if (clrCnt) begin
        mTrig = 0; mX = 0; mY = 0;
      end else begin
        if (fire && mTrig < CMAX) mTrig++;
        if (xc && !mPrevX && mX < CMAX) mX++;
        if (yc && !mPrevY && mY < CMAX) mY++;
      end
      mPulse = fire;
      if (fire) mDead = int'(deadTime);
      else if (mDead > 0) mDead--;
      mPrevA = ac; mPrevX = xc; mPrevY = yc;
      sX = xFold; sY = yFold; sEn = layerEnable;
    end
  end

  // Compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(trigPulse == mPulse, "R5/R6 pulse vs model", trigPulse, mPulse);
      check(int'(trigCount) == mTrig, "R7 trigCount vs model", trigCount, mTrig);
      check(int'(xHitCount) == mX, "R8 xHitCount vs model", xHitCount, mX);
      check(int'(yHitCount) == mY, "R8 yHitCount vs model", yHitCount, mY);
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [NL*NF-1:0] mk(input int start, input int len, input int m);
    logic [NL*NF-1:0] v = '0;
    for (int l = start; l < start + len; l++)
      if (l >= 0 && l < NL) v[l*NF + m - 1] = 1'b1;
    return v;
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clearCounts();
    @(negedge clk);
    xFold = '0; yFold = '0; clrCnt = 1'b1;
    @(negedge clk);
    clrCnt = 1'b0;
    idle(3);
  endtask

  // Drive a pattern for one cycle, then quiet for 'gap' cycles
  task automatic shot(input logic [NL*NF-1:0] px, input logic [NL*NF-1:0] py, input int gapN);
    xFold = px; yFold = py;
    @(negedge clk);
    xFold = '0; yFold = '0;
    idle(gapN);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired, actual 1 expected 0");
    finishRun();
  end

  initial begin
    // R1 reset state
    idle(3);
    check(trigPulse == 1'b0, "R1 pulse in reset", trigPulse, 0);
    check(trigCount == 0 && xHitCount == 0 && yHitCount == 0, "R1 counters in reset",
          trigCount + xHitCount + yHitCount, 0);
    rst_n = 1'b1;
    idle(2);
    check(trigCount == 0, "R1 counter after reset", trigCount, 0);

    // R2 latency and bit layout at the top of the stack, R5 single pulse while held
    xFold = mk(12, 2, 4);
    @(negedge clk);
    check(trigPulse == 1'b0, "R2 no pulse after first edge", trigPulse, 0);
    @(negedge clk);
    check(trigPulse == 1'b1, "R2 pulse after second edge", trigPulse, 1);
    @(negedge clk);
    check(trigPulse == 1'b0, "R5 held condition gives one pulse", trigPulse, 0);
    idle(3);
    check(trigCount == 1, "R5 one count while held", trigCount, 1);
    xFold = '0;
    clearCounts();

    // R3 each fold at its needed run length, then one layer short
    for (int m = 1; m <= NF; m++) begin
      shot(mk(3, 6 - m, m), '0, 4);
      check(trigCount == 1, "R3 full run triggers", trigCount, 1);
      shot(mk(3, 5 - m, m), '0, 4);
      check(trigCount == 1, "R3 short run does not trigger", trigCount, 1);
      clearCounts();
    end
    // R3 mixed folds do not combine
    shot(mk(0, 3, 1) | mk(3, 2, 2), '0, 4);
    check(trigCount == 0, "R3 mixed folds no trigger", trigCount, 0);

    // R4 disabled layer breaks a run
    layerEnable = '1;
    layerEnable[5] = 1'b0;
    shot(mk(3, 5, 1), '0, 4);
    check(trigCount == 0, "R4 masked layer breaks run", trigCount, 0);
    shot(mk(6, 5, 1), '0, 4);
    check(trigCount == 1, "R4 run beside masked layer", trigCount, 1);
    layerEnable = '1;
    clearCounts();

    // R5 Y plane alone, then both planes together
    shot('0, mk(7, 3, 3), 4);
    check(trigCount == 1 && yHitCount == 1 && xHitCount == 0, "R5 Y plane triggers",
          trigCount, 1);
    shot(mk(0, 4, 2), mk(9, 2, 4), 4);
    check(trigCount == 2, "R5 both planes one trigger", trigCount, 2);
    check(xHitCount == 1 && yHitCount == 2, "R8 both plane counters", xHitCount + yHitCount, 3);
    // R8 Y rises while X is held: no new trigger, Y counter moves
    xFold = mk(0, 5, 1);
    idle(4);
    yFold = mk(0, 2, 4);
    idle(4);
    xFold = '0; yFold = '0;
    idle(4);
    check(trigCount == 3, "R8 later plane adds no trigger", trigCount, 3);
    check(yHitCount == 3, "R8 later plane still counted", yHitCount, 3);
    clearCounts();

    // R6 dead time blocks and does not defer
    deadTime = 8'd5;
    shot(mk(2, 2, 4), '0, 1);
    shot(mk(2, 2, 4), '0, 10);
    check(trigCount == 1, "R6 rise inside dead time ignored", trigCount, 1);
    check(xHitCount == 2, "R8 plane counted during dead time", xHitCount, 2);
    deadTime = 8'd0;
    shot(mk(2, 2, 4), '0, 1);
    shot(mk(2, 2, 4), '0, 10);
    check(trigCount == 3, "R6 zero dead time allows both", trigCount, 3);
    clearCounts();

    // R9 saturation
    for (int i = 0; i < CMAX + 2; i++) shot(mk(4, 3, 3), '0, 2);
    idle(3);
    check(trigCount == CMAX, "R9 trigCount saturates", trigCount, CMAX);
    check(xHitCount == CMAX, "R9 xHitCount saturates", xHitCount, CMAX);

    // R10 clear coinciding with a firing edge
    xFold = mk(4, 3, 3);
    @(negedge clk);
    clrCnt = 1'b1;
    @(negedge clk);
    clrCnt = 1'b0;
    check(trigPulse == 1'b1, "R10 pulse survives clear", trigPulse, 1);
    check(trigCount == 0 && xHitCount == 0, "R10 clear wins", trigCount + xHitCount, 0);
    xFold = '0;
    idle(4);

    // Mixed random traffic checked against the model each cycle
    for (int c = 0; c < 3000; c++) begin
      int dens = 2 + ($urandom % 3);
      for (int b = 0; b < NL*NF; b++) begin
        xFold[b] = (($urandom % dens) != 0);
        yFold[b] = (($urandom % (dens + 2)) == 0);
      end
      if (($urandom % 4) == 0) xFold = '0;
      layerEnable = (($urandom % 5) == 0) ? NL'($urandom) : '1;
      clrCnt = (($urandom % 97) == 0);
      if (($urandom % 50) == 0) deadTime = DW'($urandom % 8);
      @(negedge clk);
    end
    clrCnt = 1'b0; xFold = '0; yFold = '0;
    idle(12);
    finishRun();
  end

endmodule